// File: doc/BRIEF.md
# Test Suite Supervisor

The supervisor runs one functional test suite on a device under test and pulls the device into a safe, unpowered state when the suite cannot be loaded or the device stops reporting that it is alive. A start command opens the load phase. The block raises a load request and arms a load watchdog. A load acknowledge from the device moves the block to execution. There it raises an execute trigger and arms a separate liveness watchdog, which every alive heartbeat reloads.

When the liveness watchdog expires for the first time, the block aborts the run. It pulses a device reset for one cycle and then restarts execution. A second expiry in the same session removes device power. An expired load watchdog removes device power as well. Both failure states hold until an external clear. A suite-complete message ends the run as passed and raises the result download request.

The message decoding, the memory transfer and the result storage sit outside the block. Each of them appears here only as a single-cycle strobe or a level request.

Top module: `suite_supervisor`

## Requirements
- R1: In idle or passed, a start strobe moves the block to loading on the next edge (status 1, load_req_o high) and loads the load watchdog with load_timeout_i.
- R2: A load_ack_i seen in any of the load_timeout_i+1 cycles spent in loading moves the block to running on the next edge.
- R3: If loading spends load_timeout_i+1 cycles with no acknowledge, the block enters load-fail (status 5) with power_en_o low.
- R4: While running (status 2), exec_o is high, and the liveness watchdog is loaded with life_timeout_i on entry.
- R5: An alive_i strobe while running reloads the liveness watchdog to life_timeout_i, so life_timeout_i+1 further cycles without a heartbeat are tolerated.
- R6: The first liveness expiry after a start gives exactly one retrying cycle (status 3, dev_rst_o high, exec_o low), then running again with a fresh liveness count.
- R7: A second liveness expiry after the retry enters life-fail (status 6) with power_en_o low.
- R8: done_i while running moves the block to passed (status 4) with dload_req_o high, and it stays there until start or clear.
- R9: Load-fail and life-fail are sticky: start_i and all device strobes are ignored there, and power_en_o stays low.
- R10: status_o encodes idle=0, loading=1, running=2, retrying=3, passed=4, load-fail=5, life-fail=6. After reset it reads 0 with power_en_o high and all requests low.
- R11: Each accepted start clears the retry allowance, so a new session again gets one restart.
- R12: Within a cycle, done_i beats alive_i, alive_i beats liveness expiry, and load_ack_i beats load expiry.
- R13: clear_i returns the block to idle from any state on the next edge, which restores power_en_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a test session |
| clear_i | input | 1 | Return to idle, leaving any safe state |
| load_timeout_i | input | CNT_W | Load watchdog count |
| life_timeout_i | input | CNT_W | Liveness watchdog count |
| load_ack_i | input | 1 | Device confirmed suite load |
| alive_i | input | 1 | Device heartbeat |
| done_i | input | 1 | Device reports suite completed correctly |
| load_req_o | output | 1 | Request suite load |
| exec_o | output | 1 | Execute trigger, high while running |
| dev_rst_o | output | 1 | One-cycle device reset before a restart |
| dload_req_o | output | 1 | Request result download |
| power_en_o | output | 1 | Device power enable |
| status_o | output | 3 | Outcome code |

## Verification
Every output is decoded from the state register, so each strobe sampled at an edge shows its effect on the outputs one cycle later. A watchdog loaded with count T expires on the edge that ends the (T+1)-th cycle without the expected message. The bench drives inputs on the falling edge. A behavioural model steps on each rising edge, and all six outputs are compared against it at every falling edge. Because the comparison happens every cycle, an early or late transition by even one cycle shows up as a mismatch at the exact cycle where it occurs.

// File: rtl/suite_sup_pkg.sv
package suite_sup_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_RUN   = 3'd2,
    ST_RETRY = 3'd3,
    ST_PASS  = 3'd4,
    ST_LFAIL = 3'd5,
    ST_VFAIL = 3'd6
  } sup_state_e;

  localparam int unsigned NUM_WDOG = 2;
  localparam int unsigned WD_LOAD  = 0;
  localparam int unsigned WD_LIFE  = 1;
endpackage

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] reload_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (reload_i)    cnt_q <= reload_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sup_retry.sv
module sup_retry (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic take_i,
  output logic used_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     used_o <= 1'b0;
    else if (clr_i)  used_o <= 1'b0;
    else if (take_i) used_o <= 1'b1;
  end
endmodule

// File: rtl/sup_fsm.sv
module sup_fsm
  import suite_sup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       clear_i,
  input  logic       load_ack_i,
  input  logic       alive_i,
  input  logic       done_i,
  input  logic       load_zero_i,
  input  logic       life_zero_i,
  input  logic       retry_used_i,
  output sup_state_e state_o,
  output logic       start_take_o,
  output logic       retry_take_o,
  output logic       load_rld_o,
  output logic       load_dec_o,
  output logic       life_rld_o,
  output logic       life_dec_o
);
  sup_state_e st_q, st_d;

  always_comb begin
    st_d         = st_q;
    start_take_o = 1'b0;
    retry_take_o = 1'b0;
    load_rld_o   = 1'b0;
    load_dec_o   = 1'b0;
    life_rld_o   = 1'b0;
    life_dec_o   = 1'b0;
    if (clear_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_PASS: begin
          if (start_i) begin
            st_d         = ST_LOAD;
            start_take_o = 1'b1;
            load_rld_o   = 1'b1;
          end
        end
        ST_LOAD: begin
          if (load_ack_i) begin
            st_d       = ST_RUN;
            life_rld_o = 1'b1;
          end else if (load_zero_i) begin
            st_d = ST_LFAIL;
          end else begin
            load_dec_o = 1'b1;
          end
        end
        ST_RUN: begin
          if (done_i) begin
            st_d = ST_PASS;
          end else if (alive_i) begin
            life_rld_o = 1'b1;
          end else if (life_zero_i) begin
            if (retry_used_i) begin
              st_d = ST_VFAIL;
            end else begin
              st_d         = ST_RETRY;
              retry_take_o = 1'b1;
            end
          end else begin
            life_dec_o = 1'b1;
          end
        end
        ST_RETRY: begin
          st_d       = ST_RUN;
          life_rld_o = 1'b1;
        end
        ST_LFAIL, ST_VFAIL: st_d = st_q;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/suite_supervisor.sv
module suite_supervisor
  import suite_sup_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] load_timeout_i,
  input  logic [CNT_W-1:0] life_timeout_i,
  input  logic             load_ack_i,
  input  logic             alive_i,
  input  logic             done_i,
  output logic             load_req_o,
  output logic             exec_o,
  output logic             dev_rst_o,
  output logic             dload_req_o,
  output logic             power_en_o,
  output logic [2:0]       status_o
);
  sup_state_e state;
  logic start_take, retry_take, retry_used;
  logic [NUM_WDOG-1:0]  wd_rld, wd_dec, wd_zero;
  logic [CNT_W-1:0]     wd_val [NUM_WDOG];

  assign wd_val[WD_LOAD] = load_timeout_i;
  assign wd_val[WD_LIFE] = life_timeout_i;

  sup_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .clear_i      (clear_i),
    .load_ack_i   (load_ack_i),
    .alive_i      (alive_i),
    .done_i       (done_i),
    .load_zero_i  (wd_zero[WD_LOAD]),
    .life_zero_i  (wd_zero[WD_LIFE]),
    .retry_used_i (retry_used),
    .state_o      (state),
    .start_take_o (start_take),
    .retry_take_o (retry_take),
    .load_rld_o   (wd_rld[WD_LOAD]),
    .load_dec_o   (wd_dec[WD_LOAD]),
    .life_rld_o   (wd_rld[WD_LIFE]),
    .life_dec_o   (wd_dec[WD_LIFE])
  );

  for (genvar g = 0; g < NUM_WDOG; g++) begin : g_wdog
    sup_wdog #(.CNT_W(CNT_W)) u_wdog (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .reload_i     (wd_rld[g]),
      .dec_i        (wd_dec[g]),
      .reload_val_i (wd_val[g]),
      .zero_o       (wd_zero[g])
    );
  end

  sup_retry u_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_take),
    .take_i (retry_take),
    .used_o (retry_used)
  );

  assign load_req_o  = (state == ST_LOAD);
  assign exec_o      = (state == ST_RUN);
  assign dev_rst_o   = (state == ST_RETRY);
  assign dload_req_o = (state == ST_PASS);
  assign power_en_o  = !((state == ST_LFAIL) || (state == ST_VFAIL));
  assign status_o    = state;
endmodule

// File: rtl/sup_checker.sv
module sup_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       clear_i,
  input logic       load_ack_i,
  input logic       done_i,
  input logic       load_req_o,
  input logic       exec_o,
  input logic       dev_rst_o,
  input logic       dload_req_o,
  input logic       power_en_o,
  input logic [2:0] status_o
);
  p_fail_unpowered_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 3'd5 || status_o == 3'd6) |-> !power_en_o);

  p_fail_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 3'd5 && !clear_i) |=> (status_o == 3'd5));

  p_vfail_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 3'd6 && !clear_i) |=> (status_o == 3'd6));

  p_one_request_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_req_o, exec_o, dev_rst_o, dload_req_o}));

  p_retry_resumes_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dev_rst_o && !clear_i) |=> (exec_o && status_o == 3'd2));

  p_start_loads_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 3'd0 && start_i && !clear_i) |=> load_req_o);

  p_ack_runs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_req_o && load_ack_i && !clear_i) |=> exec_o);

  p_done_passes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && done_i && !clear_i) |=> dload_req_o);

  p_lifefail_from_run_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 3'd2 && !clear_i) |=> (status_o inside {3'd2, 3'd3, 3'd4, 3'd6}));

  p_clear_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (status_o == 3'd0 && power_en_o));
endmodule

bind suite_supervisor sup_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .clear_i     (clear_i),
  .load_ack_i  (load_ack_i),
  .done_i      (done_i),
  .load_req_o  (load_req_o),
  .exec_o      (exec_o),
  .dev_rst_o   (dev_rst_o),
  .dload_req_o (dload_req_o),
  .power_en_o  (power_en_o),
  .status_o    (status_o)
);

// File: tb/suite_supervisor_tb.sv
`timescale 1ns/1ps
module suite_supervisor_tb;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, clr = 1'b0, ack = 1'b0, alive = 1'b0, done = 1'b0;
  logic [CW-1:0] load_to = 16'd5, life_to = 16'd4;
  logic load_req, exec, dev_rst, dload, pwr;
  logic [2:0] status;

  int n_cmp = 0, n_bad = 0, cyc_cnt = 0;
  string tag = "R10";

  // reference model state: 0 idle 1 load 2 run 3 retry 4 pass 5 loadfail 6 lifefail
  int m_st = 0, m_cnt = 0;
  bit m_used = 0;

  always #10 clk = ~clk;

  suite_supervisor #(.CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .clear_i(clr),
    .load_timeout_i(load_to), .life_timeout_i(life_to),
    .load_ack_i(ack), .alive_i(alive), .done_i(done),
    .load_req_o(load_req), .exec_o(exec), .dev_rst_o(dev_rst),
    .dload_req_o(dload), .power_en_o(pwr), .status_o(status)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_used = 0;
    end else if (clr) begin
      m_st = 0;
    end else begin
      case (m_st)
        0, 4: if (start) begin m_st = 1; m_cnt = load_to; m_used = 0; end
        1: if (ack) begin m_st = 2; m_cnt = life_to; end
           else if (m_cnt == 0) m_st = 5;
           else m_cnt--;
        2: if (done) m_st = 4;
           else if (alive) m_cnt = life_to;
           else if (m_cnt == 0) begin
             if (m_used) m_st = 6;
             else begin m_st = 3; m_used = 1; end
           end else m_cnt--;
        3: begin m_st = 2; m_cnt = life_to; end
        default: ;
      endcase
    end
  end

  task automatic chk1(string sig, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", tag, sig, act, exp, cyc_cnt);
    end
  endtask

  always @(negedge clk) begin
    cyc_cnt++;
    if (rst_n) begin
      chk1("status_o", status, m_st);
      chk1("load_req_o", load_req, m_st == 1);
      chk1("exec_o", exec, m_st == 2);
      chk1("dev_rst_o", dev_rst, m_st == 3);
      chk1("dload_req_o", dload, m_st == 4);
      chk1("power_en_o", pwr, !(m_st == 5 || m_st == 6));
    end
    if (cyc_cnt > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; cyc(1); s = 1'b0;
  endtask

  task automatic expect_st(int exp);
    chk1("status_o scenario end", status, exp);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    tag = "R10"; cyc(2); expect_st(0);

    // normal pass with heartbeats
    tag = "R1"; pulse(start); cyc(1); expect_st(1);
    tag = "R2"; pulse(ack); cyc(1); expect_st(2);
    tag = "R5";
    repeat (4) begin cyc(4); pulse(alive); end
    tag = "R4"; expect_st(2);
    tag = "R8"; pulse(done); cyc(3); expect_st(4);

    // restart from passed, then load timeout
    tag = "R1"; pulse(start); cyc(1); expect_st(1);
    tag = "R3"; cyc(8); expect_st(5);
    tag = "R9"; pulse(start); pulse(ack); pulse(alive); cyc(2); expect_st(5);
    tag = "R13"; pulse(clr); cyc(1); expect_st(0);

    // ack on the last tolerated load cycle
    tag = "R12"; pulse(start); cyc(5); pulse(ack); cyc(1); expect_st(2);
    // lose heartbeat twice
    tag = "R6"; cyc(7); expect_st(2);
    tag = "R7"; cyc(6); expect_st(6);
    tag = "R9"; pulse(start); cyc(2); expect_st(6);
    tag = "R13"; pulse(clr); cyc(1); expect_st(0);

    // retry allowance restored by new start
    tag = "R11"; pulse(start); cyc(1); pulse(ack); cyc(7);
    pulse(done); cyc(1); expect_st(4);
    pulse(start); cyc(1); pulse(ack); cyc(7); expect_st(2);
    tag = "R12"; cyc(2); done = 1'b1; alive = 1'b1; cyc(1);
    done = 1'b0; alive = 1'b0; cyc(1); expect_st(4);

    // alive on the expiry cycle, then clear mid-run
    tag = "R12"; pulse(start); pulse(ack); cyc(4); pulse(alive); cyc(3); expect_st(2);
    tag = "R13"; pulse(clr); cyc(1); expect_st(0);
    load_to = 16'd0; tag = "R3"; pulse(start); cyc(3); expect_st(5);
    pulse(clr); cyc(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule